// File: doc/BRIEF.md
# Active-Priority Register Bank with Security Write Filter

This block holds the active-priority registers of an interrupt controller CPU interface. There is one bank for each of three interrupt groups: group 0, Secure group 1 and Non-secure group 1. Each register is 32 bits wide, and one bit stands for one preemption level. The preemption-bit count `PREEMPT_BITS` (4 to 7) sets how many registers each bank has. It also sets where the Secure and Non-secure priority ranges meet inside the bank.

A single write port carries a group tag, a register index and a 32-bit value. A write can come from the Non-secure group-1 view while the secure monitor level is present. Such a write must not change any bit that stands for a Secure-range priority (0 to 127). Bits that stand for Non-secure priorities (128 to 255) stay writable. The first Non-secure bit is bit `0x80 >> (8 - PREEMPT_BITS)` of the bank. When that bit is not at a register boundary, the register that contains it is written bit by bit: its lower, Secure bits are kept and its upper, Non-secure bits are taken from the data. A separate read port returns the stored value of any register combinationally.

Top module: `apr_prio_bank`

## Requirements
- R1: While `rst_n` is low, every register of every group is zero, and every read returns zero.
- R2: A write with `wr_en` high updates the addressed register to the full `wr_data` value at the next rising clock edge. This holds for group 0 (`wr_grp`=0) and Secure group 1 (`wr_grp`=1) in all cases. It also holds for Non-secure group 1 (`wr_grp`=2) when `mon_present` is low.
- R3: A Non-secure group-1 write with `mon_present` high, to a register whose index is below the boundary register, leaves that register unchanged. The boundary register is the register that holds the first Non-secure bit.
- R4: A Non-secure group-1 write with `mon_present` high, to the boundary register when the boundary offset is nonzero, keeps the stored bits below the offset and stores `wr_data` at and above it. For PREEMPT_BITS=4 the boundary is register 0, bit 8. For PREEMPT_BITS=5 it is register 0, bit 16.
- R5: A Non-secure group-1 write with `mon_present` high stores the full `wr_data` in two cases: the register index is above the boundary register, or it is the boundary register and the offset is zero. For PREEMPT_BITS=6 the boundary is register 1, bit 0. For PREEMPT_BITS=7 it is register 2, bit 0.
- R6: A write to an index at or beyond the register count is ignored, and a read of such an index returns zero.
- R7: Each group has its own bank, so a write changes only the bank named by `wr_grp`. The group code 3 names no bank: a write with code 3 is ignored, and a read with code 3 returns zero.
- R8: `rd_data` shows the stored value of register (`rd_grp`, `rd_idx`) combinationally. A read in the same cycle as a write to that register returns the value from before the write. A register with no write keeps its value.
- R9: The register count per bank is 1 for PREEMPT_BITS of 4 or 5, 2 for 6, and 4 for 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_present | input | 1 | Secure monitor level is implemented |
| wr_en | input | 1 | Write strobe |
| wr_grp | input | 2 | Write group: 0 group 0, 1 Secure group 1, 2 Non-secure group 1, 3 none |
| wr_idx | input | 2 | Write register index |
| wr_data | input | 32 | Write data |
| rd_grp | input | 2 | Read group, same encoding as `wr_grp` |
| rd_idx | input | 2 | Read register index |
| rd_data | output | 32 | Stored value of the selected register |

## Verification
A write and a read of the same register can fall in the same cycle, and the write may pass through the security merge. Every bench step drives both a write and a read of the written register. The read is checked once before the clock edge, where it must show the old value, and once after the edge, where it must show the filtered new value. The same stimulus drives four instances, one for each preemption-bit count. A single write sequence therefore exercises all of them against a behavioural model on every step: the whole-register ignore, the per-bit merge and the full write.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int WORD_W   = 32;
  localparam int MAX_REGS = 4;
  localparam int IDX_W    = 2;
  localparam int GRP_W    = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  // registers needed to hold 2**pb preemption levels, at least one
  function automatic int reg_count(input int pb);
    return ((1 << pb) + WORD_W - 1) / WORD_W;
  endfunction

  // bank-wide bit index of the lowest Non-secure priority level
  function automatic int ns_first_bit(input int pb);
    return 128 >> (8 - pb);
  endfunction

  // bits of register idx that an NS write with the monitor present must keep
  function automatic logic [WORD_W-1:0] keep_mask(input int pb, input int idx);
    int breg;
    int boff;
    breg = ns_first_bit(pb) / WORD_W;
    boff = ns_first_bit(pb) % WORD_W;
    if (idx < breg)       return '1;
    else if (idx == breg) return (WORD_W'(1) << boff) - WORD_W'(1);
    else                  return '0;
  endfunction
endpackage

// File: rtl/apr_wr_filter.sv
module apr_wr_filter
  import apr_pkg::*;
#(
  parameter int PREEMPT_BITS = 5,
  parameter int REG_IDX      = 0
) (
  input  logic              ns_guard,
  input  logic [WORD_W-1:0] cur_val,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] upd_val
);
  localparam logic [WORD_W-1:0] KEEP = keep_mask(PREEMPT_BITS, REG_IDX);

  always_comb begin
    if (ns_guard) upd_val = (cur_val & KEEP) | (wr_data & ~KEEP);
    else          upd_val = wr_data;
  end
endmodule

// File: rtl/apr_reg_bank.sv
module apr_reg_bank
  import apr_pkg::*;
#(
  parameter int PREEMPT_BITS = 5,
  parameter int GRP_ID       = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mon_present,
  input  logic                        wr_en,
  input  logic [GRP_W-1:0]            wr_grp,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [MAX_REGS-1:0][WORD_W-1:0] view
);
  localparam int NREG = reg_count(PREEMPT_BITS);

  logic grp_hit;
  logic ns_guard;

  assign grp_hit  = wr_en && (wr_grp == GRP_W'(GRP_ID));
  assign ns_guard = (GRP_ID == int'(GRP_G1NS)) && mon_present;

  for (genvar i = 0; i < MAX_REGS; i++) begin : g_reg
    if (i < NREG) begin : g_live
      logic [WORD_W-1:0] q;
      logic [WORD_W-1:0] upd_val;
      logic              upd_en;

      assign upd_en = grp_hit && (wr_idx == IDX_W'(i));

      apr_wr_filter #(
        .PREEMPT_BITS(PREEMPT_BITS),
        .REG_IDX     (i)
      ) u_filt (
        .ns_guard(ns_guard),
        .cur_val (q),
        .wr_data (wr_data),
        .upd_val (upd_val)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (upd_en) q <= upd_val;
      end

      assign view[i] = q;
    end else begin : g_absent
      assign view[i] = '0;
    end
  end
endmodule

// File: rtl/apr_prio_bank.sv
module apr_prio_bank
  import apr_pkg::*;
#(
  parameter int PREEMPT_BITS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mon_present,
  input  logic        wr_en,
  input  logic [1:0]  wr_grp,
  input  logic [1:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_grp,
  input  logic [1:0]  rd_idx,
  output logic [31:0] rd_data
);
  localparam int NUM_GRP = 3;

  logic [NUM_GRP-1:0][MAX_REGS-1:0][WORD_W-1:0] bank_view;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    apr_reg_bank #(
      .PREEMPT_BITS(PREEMPT_BITS),
      .GRP_ID      (g)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .mon_present(mon_present),
      .wr_en      (wr_en),
      .wr_grp     (wr_grp),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .view       (bank_view[g])
    );
  end

  always_comb begin
    case (grp_e'(rd_grp))
      GRP_G0:   rd_data = bank_view[0][rd_idx];
      GRP_G1S:  rd_data = bank_view[1][rd_idx];
      GRP_G1NS: rd_data = bank_view[2][rd_idx];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/apr_prio_bank_chk.sv
module apr_prio_bank_chk #(
  parameter int PREEMPT_BITS = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mon_present,
  input logic        wr_en,
  input logic [1:0]  wr_grp,
  input logic [1:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [1:0]  rd_grp,
  input logic [1:0]  rd_idx,
  input logic [31:0] rd_data
);
  localparam int CNT   = (PREEMPT_BITS <= 5) ? 1 : (PREEMPT_BITS == 6) ? 2 : 4;
  localparam int FIRST = 128 >> (8 - PREEMPT_BITS);
  localparam int BREG  = FIRST / 32;
  localparam int BOFF  = FIRST % 32;
  localparam logic [31:0] SMASK = (32'h1 << BOFF) - 32'h1;

  logic same_sel;
  assign same_sel = (rd_grp == wr_grp) && (rd_idx == wr_idx);

  assert_bad_group_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grp == 2'd3) |-> (rd_data == 32'h0));

  assert_out_of_range_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_idx) >= CNT) |-> (rd_data == 32'h0));

  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_grp == 2'd0 || wr_grp == 2'd1) && 32'(wr_idx) < CNT && same_sel)
    |=> (!($stable(rd_grp) && $stable(rd_idx)) || rd_data == $past(wr_data)));

  assert_secure_reg_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mon_present && wr_grp == 2'd2 && 32'(wr_idx) < BREG && same_sel)
    |=> (!($stable(rd_grp) && $stable(rd_idx)) || $stable(rd_data)));

  assert_secure_bits_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mon_present && wr_grp == 2'd2 && 32'(wr_idx) == BREG && same_sel)
    |=> (!($stable(rd_grp) && $stable(rd_idx)) ||
         ((rd_data & SMASK) == ($past(rd_data) & SMASK))));

  assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (!($stable(rd_grp) && $stable(rd_idx)) || $stable(rd_data)));
endmodule

bind apr_prio_bank apr_prio_bank_chk #(.PREEMPT_BITS(PREEMPT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mon_present(mon_present), .wr_en(wr_en),
  .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_grp(rd_grp), .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/tb_apr_prio_bank.sv
module tb_apr_prio_bank;
  logic        clk;
  logic        rst_n;
  logic        mon_present;
  logic        wr_en;
  logic [1:0]  wr_grp;
  logic [1:0]  wr_idx;
  logic [31:0] wr_data;
  logic [1:0]  rd_grp;
  logic [1:0]  rd_idx;
  logic [31:0] rd_o [4];

  int checks;
  int fails;
  logic [31:0] ref_m [4][3][4];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  apr_prio_bank #(.PREEMPT_BITS(5)) dut (
    .clk(clk), .rst_n(rst_n), .mon_present(mon_present), .wr_en(wr_en),
    .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_grp(rd_grp), .rd_idx(rd_idx), .rd_data(rd_o[1]));
  apr_prio_bank #(.PREEMPT_BITS(4)) dut_p4 (
    .clk(clk), .rst_n(rst_n), .mon_present(mon_present), .wr_en(wr_en),
    .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_grp(rd_grp), .rd_idx(rd_idx), .rd_data(rd_o[0]));
  apr_prio_bank #(.PREEMPT_BITS(6)) dut_p6 (
    .clk(clk), .rst_n(rst_n), .mon_present(mon_present), .wr_en(wr_en),
    .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_grp(rd_grp), .rd_idx(rd_idx), .rd_data(rd_o[2]));
  apr_prio_bank #(.PREEMPT_BITS(7)) dut_p7 (
    .clk(clk), .rst_n(rst_n), .mon_present(mon_present), .wr_en(wr_en),
    .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_grp(rd_grp), .rd_idx(rd_idx), .rd_data(rd_o[3]));

  function automatic int nregs(input int pb);
    if (pb <= 5) return 1;
    if (pb == 6) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] model_next(input int k, input int g, input int i,
                                             input logic [31:0] d, input logic [31:0] old,
                                             input logic sec);
    int pb;
    int fb;
    int breg;
    int boff;
    logic [31:0] m;
    pb   = k + 4;
    fb   = 128 >> (8 - pb);
    breg = fb / 32;
    boff = fb % 32;
    if (i >= nregs(pb)) return old;
    if (g == 2 && sec) begin
      if (i < breg) return old;
      if (i == breg && boff != 0) begin
        m = (32'h1 << boff) - 32'h1;
        return (old & m) | (d & ~m);
      end
    end
    return d;
  endfunction

  function automatic logic [31:0] model_rd(input int k, input int g, input int i);
    if (g > 2 || i >= nregs(k + 4)) return 32'h0;
    return ref_m[k][g][i];
  endfunction

  task automatic compare(input string tag);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] exp_v;
      exp_v = model_rd(k, int'(rd_grp), int'(rd_idx));
      checks++;
      if (rd_o[k] !== exp_v) begin
        fails++;
        $display("FAIL %s pb=%0d grp=%0d idx=%0d actual=%08h expected=%08h",
                 tag, k + 4, rd_grp, rd_idx, rd_o[k], exp_v);
      end
    end
  endtask

  // drive one write plus a read of (rg,ri); check before and after the edge
  task automatic step(input logic sec, input int g, input int i, input logic [31:0] d,
                      input int rg, input int ri, input string tag);
    mon_present = sec;
    wr_en   = 1'b1;
    wr_grp  = 2'(g);
    wr_idx  = 2'(i);
    wr_data = d;
    rd_grp  = 2'(rg);
    rd_idx  = 2'(ri);
    #1;
    compare({tag, " pre-edge"});
    @(posedge clk);
    if (g < 3)
      for (int k = 0; k < 4; k++)
        ref_m[k][g][i] = model_next(k, g, i, d, ref_m[k][g][i], sec);
    #5;
    compare({tag, " post-edge"});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n = 1'b0;
    mon_present = 1'b0;
    wr_en = 1'b0;
    wr_grp = '0;
    wr_idx = '0;
    wr_data = '0;
    rd_grp = '0;
    rd_idx = '0;
    for (int k = 0; k < 4; k++)
      for (int g = 0; g < 3; g++)
        for (int i = 0; i < 4; i++) ref_m[k][g][i] = 32'h0;
    repeat (3) @(posedge clk);
    // R1: reset state of every register, checked while reset is held
    for (int g = 0; g < 4; g++)
      for (int i = 0; i < 4; i++) begin
        rd_grp = 2'(g);
        rd_idx = 2'(i);
        #1;
        compare("R1");
      end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    step(1'b1, 0, 0, 32'hFFFF_FFFF, 0, 0, "R2");
    step(1'b1, 1, 0, 32'hA5A5_A5A5, 1, 0, "R2");
    step(1'b0, 2, 0, 32'hFFFF_FFFF, 2, 0, "R2");
    step(1'b1, 2, 0, 32'h0000_0000, 2, 0, "R4");
    step(1'b0, 2, 1, 32'h0F0F_0F0F, 2, 1, "R9");
    step(1'b1, 2, 1, 32'h0000_0000, 2, 1, "R3");
    step(1'b1, 2, 2, 32'hDEAD_BEEF, 2, 2, "R5");
    step(1'b1, 2, 3, 32'hCAFE_F00D, 2, 3, "R5");
    step(1'b1, 2, 0, 32'h1234_5678, 2, 0, "R4");
    step(1'b0, 0, 3, 32'hFFFF_FFFF, 0, 3, "R6");
    step(1'b1, 0, 1, 32'h5555_AAAA, 0, 1, "R9");
    step(1'b1, 3, 0, 32'hFFFF_FFFF, 3, 0, "R7");
    step(1'b1, 0, 0, 32'h0000_0000, 2, 0, "R7");
    step(1'b1, 1, 0, 32'h1111_2222, 1, 0, "R8");
    step(1'b0, 2, 2, 32'h0000_0001, 2, 2, "R2");

    // R7: final sweep, every bank read back with no write pending
    for (int g = 0; g < 4; g++)
      for (int i = 0; i < 4; i++) begin
        rd_grp = 2'(g);
        rd_idx = 2'(i);
        #1;
        compare("R7");
      end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule